// File: doc/BRIEF.md
# Configuration-Port Unlock Front End

This block is the configuration front end of a legacy I/O-port peripheral controller. The host reaches it through two adjacent 8-bit ports. The lower address is the index port and the next address is the data port. A strap input picks which of two base addresses the pair answers at. The configuration space starts out sealed. It opens only after the host writes a magic key byte to the index port twice in a row. It seals again when a separate lock byte is written there.

While the space is open, the host writes a register number to the index port and then reads or writes that register through the data port. Global registers below 0x30 hold three things: a logical-device number, a device identity with a revision, and a fixed vendor code. Indexes from 0x30 upward form a window onto the device-specific registers of one logical device. The block forwards window accesses to that device on a strobed side port, but only while the logical-device number selects it.

Host reads are answered one clock after the read strobe, with a read-valid pulse. The host port has no back-pressure: each strobe is taken in the cycle it is presented. The host issues at most one of read or write per cycle.

Top module: `sio_cfg_gate`

## Requirements
- R1: The index port is at 0x2E and the data port at 0x2F when `strap_alt` is 0. They move to 0x4E and 0x4F when `strap_alt` is 1. Accesses to any other address produce no read response and change no state.
- R2: Configuration mode opens only after two consecutive index-port writes of 0x87.
- R3: After one 0x87, an index-port write of any other value returns the unlock sequence to its start. A further single 0x87 then leaves the space still locked.
- R4: While open, an index-port write of 0xAA locks the space. Later data-port and index-port reads then return 0xFF.
- R5: While locked (including straight after reset), data-port reads return 0xFF and data-port writes change nothing.
- R6: Index 0x07 is the logical-device select. It is readable and writable, and resets to 0x00.
- R7: Indexes 0x20 and 0x21 return the device ID high and low bytes (default 0x0909). Index 0x22 returns the revision (default 0x01). Indexes 0x23 and 0x24 return 0x19 and 0x34.
- R8: With the select at 0x06, a data-port write at index 0x30 or above pulses `win_wr` in the same cycle, with `win_idx` set to the index and `win_wdata` set to the byte. A data-port read there pulses `win_rd` and returns `win_rdata`.
- R9: With any other select value, window-range reads return 0x00 and writes raise no `win_wr`.
- R10: `rd_vld` is high for exactly the cycle after an accepted read strobe. While the space is open, an index-port read returns the current index.
- R11: Global indexes below 0x30 that are not listed above read 0x00 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_alt | input | 1 | Base address select: 0 = 0x2E, 1 = 0x4E |
| io_wr | input | 1 | Host write strobe |
| io_rd | input | 1 | Host read strobe |
| io_addr | input | 16 | Host I/O address |
| io_wdata | input | 8 | Host write byte |
| io_rdata | output | 8 | Read byte, valid with rd_vld |
| rd_vld | output | 1 | Read response, one cycle after io_rd |
| win_wr | output | 1 | Window write strobe to the selected logical device |
| win_rd | output | 1 | Window read strobe to the selected logical device |
| win_idx | output | 8 | Window register index |
| win_wdata | output | 8 | Window write byte |
| win_rdata | input | 8 | Window read byte, sampled in the win_rd cycle |

## Verification
The unlock path is tried with three patterns: a clean double key, a key broken by another byte, and a lone key after a break. Locked reads of 0xFF separate a correct sequencer from one that merely counts keys or ignores the break. Register traffic is tried in four settings: before unlocking, after unlocking, after relocking, and at the alternate base. This tells the gate state apart from the address decode. Window traffic runs once with the matching select and once with another, both above and below 0x30, to show that forwarding depends on both the select and the index range.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
  typedef enum logic [1:0] {
    KS_SEALED = 2'd0,
    KS_ARMED  = 2'd1,
    KS_OPEN   = 2'd2
  } key_state_t;

  localparam logic [7:0]  KEY_OPEN_BYTE  = 8'h87;
  localparam logic [7:0]  KEY_SEAL_BYTE  = 8'hAA;
  localparam logic [7:0]  IDX_LDSEL      = 8'h07;
  localparam logic [7:0]  IDX_DEVID_HI   = 8'h20;
  localparam logic [7:0]  IDX_DEVID_LO   = 8'h21;
  localparam logic [7:0]  IDX_REV        = 8'h22;
  localparam logic [7:0]  IDX_VEND_HI    = 8'h23;
  localparam logic [7:0]  IDX_VEND_LO    = 8'h24;
  localparam logic [15:0] VENDOR_CODE    = 16'h1934;
  localparam logic [7:0]  SEALED_READ    = 8'hFF;
endpackage

// File: rtl/sio_key_seq.sv
module sio_key_seq
  import sio_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_wr,
  input  logic [7:0] idx_val,
  output logic       is_open,
  output logic [7:0] cur_idx
);
  key_state_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (idx_wr) begin
      unique case (st_q)
        KS_SEALED: if (idx_val == KEY_OPEN_BYTE) st_d = KS_ARMED;
        KS_ARMED:  st_d = (idx_val == KEY_OPEN_BYTE) ? KS_OPEN : KS_SEALED;
        KS_OPEN:   if (idx_val == KEY_SEAL_BYTE) st_d = KS_SEALED;
        default:   st_d = KS_SEALED;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= KS_SEALED;
      cur_idx <= 8'h00;
    end else begin
      st_q <= st_d;
      if (idx_wr && st_q == KS_OPEN && idx_val != KEY_SEAL_BYTE)
        cur_idx <= idx_val;
    end
  end

  assign is_open = (st_q == KS_OPEN);

  AST_OPEN_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(is_open) |-> $past(idx_wr && idx_val == KEY_OPEN_BYTE)); // R2
  AST_SEAL_ON_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    (is_open && idx_wr && idx_val == KEY_SEAL_BYTE) |=> !is_open); // R4
endmodule

// File: rtl/sio_glob_regs.sv
module sio_glob_regs
  import sio_cfg_pkg::*;
#(
  parameter logic [15:0] DEV_ID  = 16'h0909,
  parameter logic [7:0]  DEV_REV = 8'h01
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       open_i,
  input  logic       dat_wr,
  input  logic [7:0] idx,
  input  logic [7:0] wdata,
  output logic [7:0] ldn,
  output logic [7:0] rd_val
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ldn <= 8'h00;
    else if (open_i && dat_wr && idx == IDX_LDSEL)
      ldn <= wdata;
  end

  always_comb begin
    unique case (idx)
      IDX_LDSEL:    rd_val = ldn;
      IDX_DEVID_HI: rd_val = DEV_ID[15:8];
      IDX_DEVID_LO: rd_val = DEV_ID[7:0];
      IDX_REV:      rd_val = DEV_REV;
      IDX_VEND_HI:  rd_val = VENDOR_CODE[15:8];
      IDX_VEND_LO:  rd_val = VENDOR_CODE[7:0];
      default:      rd_val = 8'h00;
    endcase
  end

  AST_LDN_HELD_SEALED: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(open_i) |-> $stable(ldn)); // R5
endmodule

// File: rtl/sio_ld_window.sv
module sio_ld_window #(
  parameter logic [7:0] WIN_LDN = 8'h06,
  parameter logic [7:0] WIN_LO  = 8'h30
) (
  input  logic       open_i,
  input  logic [7:0] ldn,
  input  logic [7:0] idx,
  input  logic       dat_wr,
  input  logic       dat_rd,
  input  logic [7:0] wdata,
  input  logic [7:0] dev_rdata,
  output logic       in_range,
  output logic       dev_wr,
  output logic       dev_rd,
  output logic [7:0] dev_idx,
  output logic [7:0] dev_wdata,
  output logic [7:0] rd_val
);
  logic selected;

  assign in_range  = (idx >= WIN_LO);
  assign selected  = open_i && in_range && (ldn == WIN_LDN);
  assign dev_wr    = selected && dat_wr;
  assign dev_rd    = selected && dat_rd;
  assign dev_idx   = idx;
  assign dev_wdata = wdata;
  assign rd_val    = selected ? dev_rdata : 8'h00;
endmodule

// File: rtl/sio_cfg_gate.sv
module sio_cfg_gate
  import sio_cfg_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter logic [15:0] BASE_PRI = 16'h002E,
  parameter logic [15:0] BASE_ALT = 16'h004E,
  parameter logic [15:0] DEV_ID   = 16'h0909,
  parameter logic [7:0]  DEV_REV  = 8'h01,
  parameter logic [7:0]  WIN_LDN  = 8'h06,
  parameter logic [7:0]  WIN_LO   = 8'h30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_alt,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  output logic              rd_vld,
  output logic              win_wr,
  output logic              win_rd,
  output logic [7:0]        win_idx,
  output logic [7:0]        win_wdata,
  input  logic [7:0]        win_rdata
);
  localparam logic [ADDR_W-1:0] IDX_PORT_PRI = ADDR_W'(BASE_PRI);
  localparam logic [ADDR_W-1:0] IDX_PORT_ALT = ADDR_W'(BASE_ALT);

  logic [ADDR_W-1:0] idx_port;
  logic              hit_idx, hit_dat;
  logic              is_open, in_range;
  logic [7:0]        cur_idx, ldn, glob_val, win_val, rd_next;

  assign idx_port = strap_alt ? IDX_PORT_ALT : IDX_PORT_PRI;
  assign hit_idx  = (io_addr == idx_port);
  assign hit_dat  = (io_addr == idx_port + ADDR_W'(1));

  sio_key_seq u_key (
    .clk     (clk),
    .rst_n   (rst_n),
    .idx_wr  (io_wr && hit_idx),
    .idx_val (io_wdata),
    .is_open (is_open),
    .cur_idx (cur_idx)
  );

  sio_glob_regs #(.DEV_ID(DEV_ID), .DEV_REV(DEV_REV)) u_glob (
    .clk    (clk),
    .rst_n  (rst_n),
    .open_i (is_open),
    .dat_wr (io_wr && hit_dat),
    .idx    (cur_idx),
    .wdata  (io_wdata),
    .ldn    (ldn),
    .rd_val (glob_val)
  );

  sio_ld_window #(.WIN_LDN(WIN_LDN), .WIN_LO(WIN_LO)) u_win (
    .open_i    (is_open),
    .ldn       (ldn),
    .idx       (cur_idx),
    .dat_wr    (io_wr && hit_dat),
    .dat_rd    (io_rd && hit_dat),
    .wdata     (io_wdata),
    .dev_rdata (win_rdata),
    .in_range  (in_range),
    .dev_wr    (win_wr),
    .dev_rd    (win_rd),
    .dev_idx   (win_idx),
    .dev_wdata (win_wdata),
    .rd_val    (win_val)
  );

  always_comb begin
    if (!is_open)     rd_next = SEALED_READ;
    else if (hit_idx) rd_next = cur_idx;
    else if (in_range) rd_next = win_val;
    else              rd_next = glob_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_vld   <= 1'b0;
      io_rdata <= 8'h00;
    end else begin
      rd_vld <= io_rd && (hit_idx || hit_dat);
      if (io_rd && (hit_idx || hit_dat))
        io_rdata <= rd_next;
    end
  end

  AST_RDVLD_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_vld |-> $past(io_rd)); // R10
  AST_SEALED_READS_FF: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_vld && !$past(is_open)) |-> io_rdata == SEALED_READ); // R5
  AST_WIN_NEEDS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (win_wr || win_rd) |-> is_open); // R8
endmodule

// File: tb/sio_cfg_gate_bench.sv
module sio_cfg_gate_bench;
  localparam int OP_WR = 0, OP_RD = 1, OP_NR = 2, OP_WN = 3;
  localparam int NV = 32;
  // fields: op[35:32] addr[31:16] value[15:8] requirement[7:0]
  localparam logic [35:0] VEC [NV] = '{
    {4'd1, 16'h002F, 8'hFF, 8'd5},  // R5 sealed read
    {4'd0, 16'h002F, 8'h06, 8'd5},  // R5 sealed write ignored
    {4'd0, 16'h002E, 8'h87, 8'd2},  // R2 first key
    {4'd0, 16'h002E, 8'h07, 8'd3},  // R3 break
    {4'd0, 16'h002E, 8'h87, 8'd3},  // R3 lone key
    {4'd1, 16'h002F, 8'hFF, 8'd3},  // R3 still sealed
    {4'd0, 16'h002E, 8'h87, 8'd2},  // R2 second key opens
    {4'd0, 16'h002E, 8'h20, 8'd7},  // R7
    {4'd1, 16'h002F, 8'h09, 8'd7},
    {4'd0, 16'h002E, 8'h21, 8'd7},
    {4'd1, 16'h002F, 8'h09, 8'd7},
    {4'd0, 16'h002E, 8'h22, 8'd7},
    {4'd1, 16'h002F, 8'h01, 8'd7},
    {4'd0, 16'h002E, 8'h23, 8'd7},
    {4'd1, 16'h002F, 8'h19, 8'd7},
    {4'd0, 16'h002E, 8'h24, 8'd7},
    {4'd1, 16'h002F, 8'h34, 8'd7},
    {4'd0, 16'h002E, 8'h07, 8'd6},  // R6 select reset value
    {4'd1, 16'h002F, 8'h00, 8'd6},
    {4'd0, 16'h002F, 8'h03, 8'd6},
    {4'd1, 16'h002F, 8'h03, 8'd6},
    {4'd1, 16'h002E, 8'h07, 8'd10}, // R10 index readback
    {4'd2, 16'h004E, 8'h00, 8'd1},  // R1 foreign address
    {4'd0, 16'h002E, 8'h10, 8'd11}, // R11
    {4'd0, 16'h002F, 8'h55, 8'd11},
    {4'd1, 16'h002F, 8'h00, 8'd11},
    {4'd0, 16'h002E, 8'h40, 8'd9},  // R9 other select
    {4'd3, 16'h002F, 8'h77, 8'd9},
    {4'd1, 16'h002F, 8'h00, 8'd9},
    {4'd0, 16'h002E, 8'hAA, 8'd4},  // R4 seal
    {4'd1, 16'h002F, 8'hFF, 8'd4},
    {4'd1, 16'h002E, 8'hFF, 8'd4}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strap_alt = 1'b0;
  logic        io_wr = 1'b0, io_rd = 1'b0;
  logic [15:0] io_addr = 16'h0;
  logic [7:0]  io_wdata = 8'h0;
  logic [7:0]  io_rdata, win_idx, win_wdata;
  logic        rd_vld, win_wr, win_rd;
  logic [7:0]  win_rdata = 8'h5C;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  sio_cfg_gate u_sio_cfg_gate (
    .clk(clk), .rst_n(rst_n), .strap_alt(strap_alt),
    .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_rdata(io_rdata), .rd_vld(rd_vld),
    .win_wr(win_wr), .win_rd(win_rd), .win_idx(win_idx), .win_wdata(win_wdata),
    .win_rdata(win_rdata)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk); io_wr = 1'b0;
  endtask

  task automatic do_rd(input logic [15:0] a, output logic v, output logic [7:0] d);
    @(negedge clk); io_addr = a; io_rd = 1'b1;
    @(negedge clk); io_rd = 1'b0; v = rd_vld; d = io_rdata;
  endtask

  initial begin : watchdog
    #1000000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic v; logic [7:0] d;
    string tag;
    repeat (3) @(negedge clk);
    chk("R10 reset rd_vld", {15'd0, rd_vld}, 16'd0);
    chk("R8 reset win_wr", {15'd0, win_wr}, 16'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      tag = $sformatf("R%0d vec%0d", VEC[i][7:0], i);
      case (int'(VEC[i][35:32]))
        OP_WR: do_wr(VEC[i][31:16], VEC[i][15:8]);
        OP_WN: begin
          @(negedge clk); io_addr = VEC[i][31:16]; io_wdata = VEC[i][15:8]; io_wr = 1'b1;
          #1 chk(tag, {15'd0, win_wr}, 16'd0);
          @(negedge clk); io_wr = 1'b0;
        end
        OP_RD: begin
          do_rd(VEC[i][31:16], v, d);
          chk(tag, {7'd0, v, d}, {8'h01, VEC[i][15:8]});
        end
        default: begin
          do_rd(VEC[i][31:16], v, d);
          chk(tag, {15'd0, v}, 16'd0);
        end
      endcase
    end

    // R1 alternate base
    strap_alt = 1'b1;
    do_wr(16'h004E, 8'h87); do_wr(16'h004E, 8'h87);
    do_wr(16'h004E, 8'h23);
    do_rd(16'h004F, v, d);
    chk("R1 alt base vendor", {7'd0, v, d}, 16'h0119);
    do_wr(16'h002E, 8'hAA);
    do_rd(16'h004F, v, d);
    chk("R1 old base ignored", {7'd0, v, d}, 16'h0119);

    // R8 window forwarding
    do_wr(16'h004E, 8'h07); do_wr(16'h004F, 8'h06);
    do_wr(16'h004E, 8'h35);
    @(negedge clk); io_addr = 16'h004F; io_wdata = 8'hC3; io_wr = 1'b1;
    #1 chk("R8 win_wr pulse", {win_wr, 7'd0, win_idx}, {1'b1, 7'd0, 8'h35});
    chk("R8 win_wdata", {8'd0, win_wdata}, 16'h00C3);
    @(negedge clk); io_wr = 1'b0;
    #1 chk("R8 win_wr single", {15'd0, win_wr}, 16'd0);
    @(negedge clk); io_addr = 16'h004F; io_rd = 1'b1;
    #1 chk("R8 win_rd pulse", {15'd0, win_rd}, 16'd1);
    @(negedge clk); io_rd = 1'b0; v = rd_vld; d = io_rdata;
    chk("R8 window read", {7'd0, v, d}, 16'h015C);

    // R11 below window with select matching
    do_wr(16'h004E, 8'h2F);
    @(negedge clk); io_addr = 16'h004F; io_wdata = 8'h11; io_wr = 1'b1;
    #1 chk("R11 no win_wr below 0x30", {15'd0, win_wr}, 16'd0);
    @(negedge clk); io_wr = 1'b0;
    do_rd(16'h004F, v, d);
    chk("R11 unused global", {7'd0, v, d}, 16'h0100);

    // R10 strobe lasts one cycle
    @(negedge clk);
    chk("R10 rd_vld one cycle", {15'd0, rd_vld}, 16'd0);

    // R5 after reset, sealed again and select cleared
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
    do_rd(16'h004F, v, d);
    chk("R5 sealed after reset", {7'd0, v, d}, 16'h01FF);
    do_wr(16'h004E, 8'h87); do_wr(16'h004E, 8'h87);
    do_wr(16'h004E, 8'h07);
    do_rd(16'h004F, v, d);
    chk("R6 select cleared by reset", {7'd0, v, d}, 16'h0100);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule